// File: doc/BRIEF.md
# PHY Management Bus Controller

This block lets a host reach the registers of an external PHY over a two-wire management bus. The host sees two 32-bit registers. One is a packed command word holding the PHY address, the register number, a clock-range code, a direction flag and a busy flag. The other is a data word whose low 16 bits carry the value exchanged with the PHY.

To send a value, the host first places it in the data word. It then writes the command word with the busy flag set and the direction flag set. To fetch a value, the host writes the command word with busy set and the direction flag clear. It then polls until busy drops and reads the captured value from the data word.

While busy is set the block generates the management clock by dividing the system clock. It shifts out one frame of 64 bit slots. For a read it releases the data line and samples the PHY's reply.

Top module: `mdio_mgmt_if`

## Requirements
- R1: After reset the command word and data word read back as zero, `mdc` is 0 and `mdio_oe` is 0.
- R2: A command write (`wr_sel`=0) with bit 0 (busy) set starts one frame, and busy reads back 1 while the frame runs. A command write with bit 0 clear stores the fields, where bit 1 is the write flag, bits 4:2 are the clock code, bits 9:5 are the register number and bits 14:10 are the PHY address. Such a write starts no frame.
- R3: Busy clears by itself once the 64th `mdc` cycle ends, which is its falling edge.
- R4: A write frame, sampled at each rising edge of `mdc`, carries the following bits in order:
  - 32 ones;
  - 01;
  - 01;
  - the PHY address, MSB first;
  - the register number, MSB first;
  - 1 then 0;
  - the 16-bit data word, MSB first.

  `mdio_oe` is 1 in every slot.
- R5: A read frame carries the same preamble, start code, addresses and field order as a write frame, with opcode 10 in place of 01. `mdio_oe` is 1 for the first 46 slots and 0 for the two turnaround slots and the 16 data slots.
- R6: On a read, the 16 values of `mdio_i` sampled at the rising edges of data slots 48 to 63 are loaded into the data word, MSB first, by the time busy clears.
- R7: One `mdc` period lasts the following number of system-clock cycles, selected by the clock code: 42 for code 0, 62 for code 1, 16 for code 2, 26 for code 3, 102 for code 4, and 124 for codes 5, 6 and 7. `mdc` is low for the first half of the period and high for the second.
- R8: While a frame runs, `mdio_o` changes only in the cycle in which `mdc` falls, apart from the first slot, which is presented when the frame starts.
- R9: A command write while busy is 1 is ignored: the stored fields and the frame in progress are unchanged.
- R10: While busy is 0, `mdc` and `mdio_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 1 | Write target: 0 command word, 1 data word |
| wr_data | input | 32 | Host write value |
| rd_sel | input | 1 | Read target: 0 command word, 1 data word |
| rd_data | output | 32 | Selected register value (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | Drive enable for `mdio_o` |
| mdio_i | input | 1 | Management data returned by the PHY |

## Verification
The assertions assume that the host writes only through single-cycle strobes that are synchronous to `clk`. They also assume that `mdio_i` is changed by the PHY side only while `mdc` is low, so each rising-edge sample sees a settled value. The bench acts as the PHY. It drives `mdio_i` just after each falling edge of `mdc` and drives its host strobes on falling edges of `clk`. A command write is issued on purpose in the middle of a frame, to exercise the ignore path.

// File: rtl/mdio_mgmt_pkg.sv
// Shared constants for the management bus controller: command-word field
// positions, frame geometry and the clock-code to divisor mapping.
// Assumes the standard 5-bit address fields and 16-bit data.
package mdio_mgmt_pkg;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 16;
    localparam int CODE_W    = 3;
    localparam int PRE_LEN   = 32;
    localparam int FRAME_LEN = PRE_LEN + 2 + 2 + 2 * ADDR_W + 2 + DATA_W;

    localparam int F_BUSY  = 0;
    localparam int F_WRITE = 1;
    localparam int F_CODE  = 2;
    localparam int F_REG   = F_CODE + CODE_W;
    localparam int F_PHY   = F_REG + ADDR_W;

    localparam int HALF_W  = 7;

    // Half of the MDC period, in system-clock cycles, for a clock code.
    function automatic logic [HALF_W-1:0] half_period(input logic [CODE_W-1:0] code);
        int unsigned div;
        case (code)
            3'd0:    div = 42;
            3'd1:    div = 62;
            3'd2:    div = 16;
            3'd3:    div = 26;
            3'd4:    div = 102;
            default: div = 124;
        endcase
        return HALF_W'(div / 2);
    endfunction
endpackage

// File: rtl/mdio_clk_div.sv
// MDC generator. While run is high it produces a clock that is low for one
// half period and then high for one half period. It flags the cycle in
// which MDC is about to rise or fall. Assumes code is held stable while
// run is high.
module mdio_clk_div
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              mdc,
    output logic              rise_stb,
    output logic              fall_stb
);
    logic [HALF_W-1:0] cnt;
    logic [HALF_W-1:0] half;
    logic              at_end;

    // Decode the half period and detect the last cycle of a half.
    always_comb begin
        half     = half_period(code);
        at_end   = run && (cnt == half - HALF_W'(1));
        rise_stb = at_end && !mdc;
        fall_stb = at_end && mdc;
    end

    // Count cycles within a half period and toggle MDC at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (at_end) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + HALF_W'(1);
        end
    end
endmodule

// File: rtl/mdio_frame_seq.sv
// Frame sequencer. It loads a full frame on start, presents one bit per
// MDC period and advances on each falling edge. It releases the line for
// the turnaround and data slots of a read and shifts in the reply on
// rising edges. Assumes is_read is held for the whole frame.
module mdio_frame_seq
    import mdio_mgmt_pkg::*;
#(
    parameter int LEN   = FRAME_LEN,
    parameter int DW    = DATA_W,
    localparam int IDX_W = $clog2(LEN),
    localparam int TA_AT = LEN - DW - 2,
    localparam int RX_AT = LEN - DW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [LEN-1:0] frame,
    input  logic           is_read,
    input  logic           rise_stb,
    input  logic           fall_stb,
    input  logic           mdio_i,
    output logic           active,
    output logic           mdio_o,
    output logic           mdio_oe,
    output logic           done,
    output logic [DW-1:0]  rx_data
);
    logic [LEN-1:0]   shreg;
    logic [IDX_W-1:0] idx;

    // Drive the current slot and decide whether the line is driven.
    always_comb begin
        mdio_o  = active && shreg[LEN-1];
        mdio_oe = active && !(is_read && (int'(idx) >= TA_AT));
        done    = active && fall_stb && (int'(idx) == LEN - 1);
    end

    // Track the slot index and shift the outgoing frame on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            shreg  <= '0;
            idx    <= '0;
        end else if (start && !active) begin
            active <= 1'b1;
            shreg  <= frame;
            idx    <= '0;
        end else if (done) begin
            active <= 1'b0;
            shreg  <= '0;
            idx    <= '0;
        end else if (active && fall_stb) begin
            shreg  <= {shreg[LEN-2:0], 1'b0};
            idx    <= idx + IDX_W'(1);
        end
    end

    // Capture reply bits on rising edges within the data slots of a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
        end else if (active && rise_stb && is_read && (int'(idx) >= RX_AT)) begin
            rx_data <= {rx_data[DW-2:0], mdio_i};
        end
    end
endmodule

// File: rtl/mdio_mgmt_if.sv
// Host register front end for the management bus. It holds the packed
// command word and the data word and builds the frame from them. It
// launches the sequencer and clears busy when the frame completes.
// Assumes single-cycle write strobes that are synchronous to clk.
module mdio_mgmt_if
    import mdio_mgmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [31:0] wr_data,
    input  logic        rd_sel,
    output logic [31:0] rd_data,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic [ADDR_W-1:0] phy_q;
    logic [ADDR_W-1:0] reg_q;
    logic [CODE_W-1:0] code_q;
    logic              wr_q;
    logic              busy_q;
    logic [DATA_W-1:0] data_q;

    logic              cmd_wr;
    logic              start;
    logic [FRAME_LEN-1:0] frame;
    logic              n_write;
    logic              active;
    logic              rise_stb;
    logic              fall_stb;
    logic              done;
    logic [DATA_W-1:0] rx_data;

    // Qualify host command writes and build the frame from the incoming word.
    always_comb begin
        cmd_wr  = wr_en && !wr_sel && !busy_q;
        start   = cmd_wr && wr_data[F_BUSY];
        n_write = wr_data[F_WRITE];
        frame   = {{PRE_LEN{1'b1}}, 2'b01,
                   n_write ? 2'b01 : 2'b10,
                   wr_data[F_PHY +: ADDR_W],
                   wr_data[F_REG +: ADDR_W],
                   n_write ? 2'b10 : 2'b00,
                   n_write ? data_q : {DATA_W{1'b0}}};
    end

    // Command word storage with the self-clearing busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phy_q  <= '0;
            reg_q  <= '0;
            code_q <= '0;
            wr_q   <= 1'b0;
            busy_q <= 1'b0;
        end else if (cmd_wr) begin
            phy_q  <= wr_data[F_PHY +: ADDR_W];
            reg_q  <= wr_data[F_REG +: ADDR_W];
            code_q <= wr_data[F_CODE +: CODE_W];
            wr_q   <= wr_data[F_WRITE];
            busy_q <= wr_data[F_BUSY];
        end else if (done) begin
            busy_q <= 1'b0;
        end
    end

    // Data word: host writes, and read results loaded at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (done && !wr_q) begin
            data_q <= rx_data;
        end else if (wr_en && wr_sel) begin
            data_q <= wr_data[DATA_W-1:0];
        end
    end

    // Host read multiplexer.
    always_comb begin
        rd_data = '0;
        if (rd_sel) begin
            rd_data[DATA_W-1:0] = data_q;
        end else begin
            rd_data[F_BUSY]             = busy_q;
            rd_data[F_WRITE]            = wr_q;
            rd_data[F_CODE +: CODE_W]   = code_q;
            rd_data[F_REG +: ADDR_W]    = reg_q;
            rd_data[F_PHY +: ADDR_W]    = phy_q;
        end
    end

    mdio_clk_div i_clk_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (active),
        .code     (code_q),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_seq i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .frame    (frame),
        .is_read  (!wr_q),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .active   (active),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .done     (done),
        .rx_data  (rx_data)
    );
endmodule

// File: rtl/mdio_mgmt_chk.sv
// Checker for the management bus controller, bound to the top module.
// Assumes the host strobes and mdio_i follow the rules stated in the brief.
module mdio_mgmt_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy_q,
    input logic       wr_q,
    input logic       wr_en,
    input logic       wr_sel,
    input logic [4:0] phy_q,
    input logic [4:0] reg_q,
    input logic       mdc,
    input logic       mdio_o,
    input logic       mdio_oe
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> (!mdc && !mdio_oe)); // R10

    AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy_q) && busy_q && !$stable(mdio_o)) |-> $fell(mdc)); // R8

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && wr_en && !wr_sel) |=> ($stable(phy_q) && $stable(reg_q))); // R9

    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && wr_q) |-> mdio_oe); // R4

    AST_MDC_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> busy_q); // R2
endmodule

bind mdio_mgmt_if mdio_mgmt_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy_q  (busy_q),
    .wr_q    (wr_q),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .phy_q   (phy_q),
    .reg_q   (reg_q),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
);

// File: tb/test_mdio_mgmt_if.sv
`timescale 1ns/1ps
module test_mdio_mgmt_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    mdio_mgmt_if i_mdio_mgmt_if (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic sel, input logic [31:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic host_rd(input logic sel, output logic [31:0] val);
        @(negedge clk);
        rd_sel = sel;
        #1 val = rd_data;
    endtask

    function automatic logic [31:0] cmd(input logic [4:0] phy, input logic [4:0] rg,
                                        input logic [2:0] code, input logic wr, input logic busy);
        return {17'b0, phy, rg, code, wr, busy};
    endfunction

    function automatic int period_of(input logic [2:0] code);
        case (code)
            3'd0: return 42;  3'd1: return 62;  3'd2: return 16;
            3'd3: return 26;  3'd4: return 102; default: return 124;
        endcase
    endfunction

    // One full transaction acting as the PHY; optional mid-frame command write.
    task automatic run_frame(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                             input logic [2:0] code, input logic [15:0] val,
                             input logic [15:0] reply, input bit poke);
        logic [63:0] cap, oecap, exp, mask, oe_exp;
        logic [31:0] r;
        time t0, t1;
        int  waited;
        if (wr) host_wr(1'b1, {16'b0, val});
        host_wr(1'b0, cmd(phy, rg, code, wr, 1'b1));
        host_rd(1'b0, r);
        check("R2 busy set", {63'b0, r[0]}, 64'd1);
        cap = '0; oecap = '0; t0 = 0; t1 = 0;
        for (int i = 0; i < 64; i++) begin
            @(posedge mdc);
            if (i == 0) t0 = $time;
            if (i == 1) t1 = $time;
            cap[63-i] = mdio_o;
            oecap[63-i] = mdio_oe;
            if (poke && i == 10) begin
                host_wr(1'b0, cmd(~phy, ~rg, code, ~wr, 1'b1));
                host_rd(1'b0, r);
                check("R9 fields held", {49'b0, r[14:0]}, {49'b0, cmd(phy, rg, code, wr, 1'b1)});
            end
            if (i != 63) begin
                @(negedge mdc);
                if (i + 1 >= 48) mdio_i = reply[15-(i+1-48)];
            end
        end
        check("R7 mdc period", 64'((t1 - t0) / 20), 64'(period_of(code)));
        exp = {32'hFFFF_FFFF, 2'b01, wr ? 2'b01 : 2'b10, phy, rg, wr ? 2'b10 : 2'b00,
               wr ? val : 16'h0};
        mask   = wr ? 64'hFFFF_FFFF_FFFF_FFFF : {{46{1'b1}}, 18'b0};
        oe_exp = mask;
        if (wr) check("R4 write frame", cap, exp);
        else    check("R5 read frame header", cap & mask, exp & mask);
        check(wr ? "R4 oe pattern" : "R5 oe pattern", oecap, oe_exp);
        waited = 0;
        r = 32'h1;
        while (r[0] && waited < 400) begin
            host_rd(1'b0, r);
            waited++;
        end
        check("R3 busy clears", {63'b0, r[0]}, 64'd0);
        check("R10 idle lines", {62'b0, mdc, mdio_oe}, 64'd0);
        host_rd(1'b1, r);
        if (wr) check("R4 data kept", {32'b0, r}, {48'b0, val});
        else    check("R6 read data", {32'b0, r}, {48'b0, reply});
        mdio_i = 1'b1;
    endtask

    task automatic t_reset;
        logic [31:0] r;
        host_rd(1'b0, r); check("R1 command word", {32'b0, r}, 64'd0);
        host_rd(1'b1, r); check("R1 data word", {32'b0, r}, 64'd0);
        check("R1 lines", {62'b0, mdc, mdio_oe}, 64'd0);
    endtask

    task automatic t_no_start;
        logic [31:0] r;
        bit rose = 0;
        host_wr(1'b0, cmd(5'h0B, 5'h13, 3'd4, 1'b1, 1'b0));
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (mdc) rose = 1;
        end
        check("R2 no frame without busy", {63'b0, rose}, 64'd0);
        host_rd(1'b0, r);
        check("R2 fields stored", {32'b0, r}, {32'b0, cmd(5'h0B, 5'h13, 3'd4, 1'b1, 1'b0)});
    endtask

    initial begin : watchdog
        #3_900_000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_no_start();
        run_frame(1'b1, 5'h15, 5'h0A, 3'd2, 16'hA5C3, 16'h0, 1'b1);
        run_frame(1'b0, 5'h01, 5'h1F, 3'd2, 16'h0, 16'h3C96, 1'b0);
        run_frame(1'b0, 5'h1E, 5'h00, 3'd0, 16'h0, 16'h8001, 1'b1);
        for (int c = 1; c < 8; c++)
            run_frame(1'b1, 5'(c), 5'(31 - c), 3'(c), 16'(16'h1234 * c), 16'h0, 1'b0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule